// File: doc/BRIEF.md
# IDE Bus-Master DMA Channel Register Block

This block holds the software-visible control state of a single IDE bus-master DMA channel. Software reaches it over a small register bus with two 32-bit words and per-byte write enables. Word 0 carries the command byte in lane 0 and the status byte in lane 2. Word 1 carries the descriptor-table pointer. A DMA engine next to the block receives an enable, a transfer direction, a one-cycle abort pulse and the address of the descriptor it should use next. The engine reports completion, errors, interrupts and each consumed descriptor back to the block.

Channel sequencing is kept in a four-state controller:
- **IDLE**: no command is running.
- **ARM**: enable was just set. The working pointer is reloaded from the last pointer software wrote.
- **RUN**: the transfer is active.
- **DONE**: the engine finished or failed while enable is still set.

The controller has these transitions:
- **start**: IDLE to ARM, taken when enable is written from 0 to 1.
- **launch**: ARM to RUN, taken on the next cycle.
- **cancel**: ARM to IDLE, taken when enable is written 0 during ARM.
- **abort**: RUN to IDLE, taken when enable is written 0 during RUN.
- **finish**: RUN to DONE, taken on engine completion or error.
- **release**: DONE to IDLE, taken when enable is written 0.

Each descriptor the engine consumes moves the working pointer on by 8 bytes. An abort throws the command away. The next start begins again at the first descriptor.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, both bus words read 0, and `dma_en`, `dma_dir`, `dma_abort` and `dma_desc_addr` are all 0.
- R2: The command byte is word 0, lane 0. Bit 0 is enable and bit 3 is direction (1 = the engine writes to memory). Bits 7:4 and 2:1 read 0 and ignore writes. Lanes 1 and 3 of word 0 read 0 and ignore writes.
- R3: The status byte is word 0, lane 2. Bit 0 is active, bit 1 is error and bit 2 is interrupt. Bit 5 is the drive-0 DMA flag and bit 6 is the drive-1 DMA flag; both are read/write. Bit 7 is read-only and reflects `cfg_simplex`. Bits 4:3 read 0.
- R4: Word 1 is the descriptor pointer. Bits 31:2 are writable per byte lane, and bits 1:0 always read 0.
- R5: After enable is written from 0 to 1, active stays 0 for one cycle (ARM) and reads 1 from the following cycle (RUN). At that point `dma_desc_addr` equals the last pointer value software wrote.
- R6: While active, each cycle with `eng_desc_used` high adds 8 to the pointer, and word 1 returns the updated value. Software writes to word 1 are ignored during ARM and RUN.
- R7: Writes to the direction bit are ignored while active is 1.
- R8: Writing enable to 0 while active drops active, returns to IDLE and produces exactly one cycle of `dma_abort`. The next start restarts from the first descriptor.
- R9: `eng_done` or `eng_err` during RUN clears active while enable stays 1 (DONE). Clearing enable afterwards gives no abort pulse.
- R10: Status bits 1 and 2 are set by `eng_err` and `eng_irq`. Writing 1 to one of them clears it; writing 0 leaves it unchanged.
- R11: When a hardware event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_waddr | input | 1 | Word select: 0 = command/status, 1 = pointer |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| cfg_simplex | input | 1 | Simplex configuration, shown in status bit 7 |
| eng_done | input | 1 | Engine completed the transfer |
| eng_err | input | 1 | Engine detected an error |
| eng_irq | input | 1 | Engine detected a drive interrupt |
| eng_desc_used | input | 1 | Engine consumed one descriptor |
| dma_en | output | 1 | Enable bit to the engine |
| dma_dir | output | 1 | Direction bit to the engine |
| dma_abort | output | 1 | One-cycle abort pulse |
| dma_desc_addr | output | 32 | Address of the next descriptor |

## Verification
Two cases can fall in the same cycle, and the bench provokes both on purpose.

The first is a hardware interrupt event landing in the same clock as a software write-one clear of that same status bit. The bench holds `eng_irq` high across the clock edge that also captures the clear. It then expects bit 2 to read back as 1, because the hardware set takes priority.

The second is a direction write that arrives while the channel is active. The bench issues it during RUN and expects the command byte and `dma_dir` to be unchanged.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int REG_W      = 32;
    localparam int BE_W       = REG_W / 8;
    localparam int DESC_BYTES = 8;
    localparam int DESC_STEP  = DESC_BYTES / 4;

    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_DIR_BIT = 3;

    localparam int STS_LANE     = 2;
    localparam int STS_ERR_BIT  = STS_LANE * 8 + 1;
    localparam int STS_IRQ_BIT  = STS_LANE * 8 + 2;
    localparam int STS_DRV0_BIT = STS_LANE * 8 + 5;
    localparam int STS_DRV1_BIT = STS_LANE * 8 + 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_DONE
    } bm_state_t;

endpackage

// File: rtl/bmdma_fsm.sv
module bmdma_fsm
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic eng_done,
    input  logic eng_err,
    output logic st_active,
    output logic st_busy,
    output logic ptr_load,
    output logic abort_pulse
);

    bm_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_set) state_d = ST_ARM;
            ST_ARM:  state_d = en_clr ? ST_IDLE : ST_RUN;
            ST_RUN: begin
                if (en_clr)                   state_d = ST_IDLE;
                else if (eng_done || eng_err) state_d = ST_DONE;
            end
            ST_DONE: if (en_clr) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        st_active = 1'b0;
        st_busy   = 1'b0;
        ptr_load  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARM: begin
                st_busy  = 1'b1;
                ptr_load = 1'b1;
            end
            ST_RUN: begin
                st_active = 1'b1;
                st_busy   = 1'b1;
            end
            ST_DONE: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) abort_pulse <= 1'b0;
        else        abort_pulse <= (state_q == ST_RUN) && en_clr;
    end

endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [REG_W-1:2] wr_data,
    input  logic             load,
    input  logic             advance,
    output logic [REG_W-1:0] cur_addr
);

    logic [REG_W-1:2] base_q, cur_q, merged;

    for (genvar b = 2; b < REG_W; b++) begin : g_lane_bit
        assign merged[b] = wr_be[b / 8] ? wr_data[b] : cur_q[b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            cur_q <= base_q;
        end else if (advance) begin
            cur_q <= cur_q + (REG_W - 2)'(DESC_STEP);
        end else if (wr_en) begin
            base_q <= merged;
            cur_q  <= merged;
        end
    end

    assign cur_addr = {cur_q, 2'b00};

endmodule

// File: rtl/bmdma_status.sv
module bmdma_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sts_we,
    input  logic       clr_err,
    input  logic       clr_irq,
    input  logic [1:0] drv_val,
    input  logic       hw_err,
    input  logic       hw_irq,
    output logic       err_flag,
    output logic       irq_flag,
    output logic [1:0] drv_flags
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            irq_flag  <= 1'b0;
            drv_flags <= 2'b00;
        end else begin
            err_flag <= hw_err | (err_flag & ~(sts_we & clr_err));
            irq_flag <= hw_irq | (irq_flag & ~(sts_we & clr_irq));
            if (sts_we) drv_flags <= drv_val;
        end
    end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [0:0]       bus_waddr,
    input  logic             bus_we,
    input  logic [BE_W-1:0]  bus_be,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             cfg_simplex,
    input  logic             eng_done,
    input  logic             eng_err,
    input  logic             eng_irq,
    input  logic             eng_desc_used,
    output logic             dma_en,
    output logic             dma_dir,
    output logic             dma_abort,
    output logic [REG_W-1:0] dma_desc_addr
);

    logic cmd_we, sts_we, ptr_we;
    logic en_q, dir_q, en_set, en_clr;
    logic st_active, st_busy, ptr_load;
    logic sts_err, sts_irq;
    logic [1:0] sts_drv;
    logic [7:0] cmd_byte, sts_byte;
    logic unused_wbit;

    assign unused_wbit = bus_wdata[1];

    assign cmd_we = bus_we && (bus_waddr == 1'b0) && bus_be[0];
    assign sts_we = bus_we && (bus_waddr == 1'b0) && bus_be[STS_LANE];
    assign ptr_we = bus_we && (bus_waddr == 1'b1) && !st_busy;

    assign en_set = cmd_we &&  bus_wdata[CMD_EN_BIT] && !en_q;
    assign en_clr = cmd_we && !bus_wdata[CMD_EN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dir_q <= 1'b0;
        end else if (cmd_we) begin
            en_q <= bus_wdata[CMD_EN_BIT];
            if (!st_active) dir_q <= bus_wdata[CMD_DIR_BIT];
        end
    end

    bmdma_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_set      (en_set),
        .en_clr      (en_clr),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .st_active   (st_active),
        .st_busy     (st_busy),
        .ptr_load    (ptr_load),
        .abort_pulse (dma_abort)
    );

    bmdma_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_we),
        .wr_be    (bus_be),
        .wr_data  (bus_wdata[REG_W-1:2]),
        .load     (ptr_load),
        .advance  (st_active && eng_desc_used),
        .cur_addr (dma_desc_addr)
    );

    bmdma_status u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .sts_we    (sts_we),
        .clr_err   (bus_wdata[STS_ERR_BIT]),
        .clr_irq   (bus_wdata[STS_IRQ_BIT]),
        .drv_val   ({bus_wdata[STS_DRV1_BIT], bus_wdata[STS_DRV0_BIT]}),
        .hw_err    (eng_err),
        .hw_irq    (eng_irq),
        .err_flag  (sts_err),
        .irq_flag  (sts_irq),
        .drv_flags (sts_drv)
    );

    assign cmd_byte = {4'b0000, dir_q, 2'b00, en_q};
    assign sts_byte = {cfg_simplex, sts_drv, 2'b00, sts_irq, sts_err, st_active};

    always_comb begin
        if (bus_waddr == 1'b0) bus_rdata = {8'h00, sts_byte, 8'h00, cmd_byte};
        else                   bus_rdata = dma_desc_addr;
    end

    assign dma_en  = en_q;
    assign dma_dir = dir_q;

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dma_en,
    input logic        dma_dir,
    input logic        dma_abort,
    input logic [31:0] dma_desc_addr,
    input logic        eng_err,
    input logic        eng_desc_used,
    input logic        st_active,
    input logic        sts_err
);

    a_r5_active_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_en) |=> (st_active || !dma_en));

    a_r8_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dma_abort |=> !dma_abort);

    a_r8_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dma_abort |-> (!dma_en && $past(st_active)));

    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dma_desc_addr[1:0] == 2'b00);

    a_r7_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && $past(st_active)) |-> $stable(dma_dir));

    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && $past(st_active)) |->
            (dma_desc_addr == $past(dma_desc_addr) + ($past(eng_desc_used) ? 32'd8 : 32'd0)));

    a_r11_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eng_err) |-> sts_err);

endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_en        (dma_en),
    .dma_dir       (dma_dir),
    .dma_abort     (dma_abort),
    .dma_desc_addr (dma_desc_addr),
    .eng_err       (eng_err),
    .eng_desc_used (eng_desc_used),
    .st_active     (st_active),
    .sts_err       (sts_err)
);

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  bus_waddr = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_simplex = 1'b0;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_irq = 1'b0, eng_desc_used = 1'b0;
    logic        dma_en, dma_dir, dma_abort;
    logic [31:0] dma_desc_addr;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bmdma_regs dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_waddr     (bus_waddr),
        .bus_we        (bus_we),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .cfg_simplex   (cfg_simplex),
        .eng_done      (eng_done),
        .eng_err       (eng_err),
        .eng_irq       (eng_irq),
        .eng_desc_used (eng_desc_used),
        .dma_en        (dma_en),
        .dma_dir       (dma_dir),
        .dma_abort     (dma_abort),
        .dma_desc_addr (dma_desc_addr)
    );

    // Monitor: pops expected items and compares with the live outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (kind_q.size() > 0) begin
                int          k;
                logic [31:0] e, act;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                case (k)
                    0:       act = bus_rdata;
                    1:       act = {29'b0, dma_abort, dma_dir, dma_en};
                    default: act = dma_desc_addr;
                endcase
                checks++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: actual %08h expected %08h", t, act, e);
                end
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input int k, input logic [31:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        #1;
    endtask

    task automatic rd(input logic [0:0] a, input logic [31:0] e, input string t);
        bus_waddr = a;
        expect_item(0, e, t);
    endtask

    task automatic wr(input logic [0:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_waddr = a;
        bus_be    = be;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
        bus_we    = 1'b0;
        bus_be    = 4'h0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(0, 32'h0, "R1 word0 reset");
        rd(1, 32'h0, "R1 word1 reset");
        expect_item(1, 32'h0, "R1 control outputs reset");
        expect_item(2, 32'h0, "R1 descriptor address reset");

        wr(0, 4'b0001, 32'h0000_00F6);
        rd(0, 32'h0, "R2 reserved command bits ignored");
        wr(0, 4'b1011, 32'hFFFF_00FE);
        rd(0, 32'h0000_0008, "R2 direction bit only, lanes 1/3 zero");
        expect_item(1, 32'h2, "R2 dma_dir follows bit 3");
        wr(0, 4'b0001, 32'h0);

        wr(1, 4'hF, 32'h1234_567F);
        rd(1, 32'h1234_567C, "R4 pointer low bits zero");
        wr(1, 4'b0010, 32'h0000_AB00);
        rd(1, 32'h1234_AB7C, "R4 pointer byte lane");

        wr(1, 4'hF, 32'h0000_1000);
        wr(0, 4'b0001, 32'h1);
        rd(0, 32'h0000_0001, "R5 not active in arm cycle");
        step();
        rd(0, 32'h0001_0001, "R5 active after arm");
        expect_item(2, 32'h1000, "R5 first descriptor");

        eng_desc_used = 1'b1; step(); eng_desc_used = 1'b0;
        expect_item(2, 32'h1008, "R6 advance by 8");
        eng_desc_used = 1'b1; step(); step(); eng_desc_used = 1'b0;
        rd(1, 32'h1018, "R6 pointer after three descriptors");
        wr(1, 4'hF, 32'hDEAD_0000);
        rd(1, 32'h1018, "R6 pointer write ignored while active");

        wr(0, 4'b0001, 32'h9);
        rd(0, 32'h0001_0001, "R7 direction write ignored while active");
        expect_item(1, 32'h1, "R7 dma_dir unchanged");

        wr(0, 4'b0001, 32'h0);
        expect_item(1, 32'h4, "R8 abort pulse");
        rd(0, 32'h0, "R8 active cleared on abort");
        step();
        expect_item(1, 32'h0, "R8 abort lasts one cycle");
        wr(0, 4'b0001, 32'h1);
        step();
        expect_item(2, 32'h1000, "R8 restart from first descriptor");

        eng_done = 1'b1; step(); eng_done = 1'b0;
        rd(0, 32'h0000_0001, "R9 done clears active, enable kept");
        wr(0, 4'b0001, 32'h0);
        expect_item(1, 32'h0, "R9 no abort after done");

        wr(0, 4'b0001, 32'h1);
        step();
        eng_err = 1'b1; step(); eng_err = 1'b0;
        rd(0, 32'h0002_0001, "R10 error set, active cleared");
        wr(0, 4'b0100, 32'h0);
        rd(0, 32'h0002_0001, "R10 writing 0 keeps error");
        wr(0, 4'b0100, 32'h0002_0000);
        rd(0, 32'h0000_0001, "R10 write 1 clears error");
        eng_irq = 1'b1; step(); eng_irq = 1'b0;
        rd(0, 32'h0004_0001, "R10 interrupt set");

        eng_irq = 1'b1;
        wr(0, 4'b0100, 32'h0004_0000);
        eng_irq = 1'b0;
        rd(0, 32'h0004_0001, "R11 hardware set wins over clear");
        wr(0, 4'b0100, 32'h0004_0000);
        rd(0, 32'h0000_0001, "R10 interrupt cleared");
        wr(0, 4'b0001, 32'h0);

        cfg_simplex = 1'b1;
        wr(0, 4'b0100, 32'h00F8_0000);
        rd(0, 32'h00E0_0000, "R3 drive flags, simplex, reserved zero");
        cfg_simplex = 1'b0;
        wr(0, 4'b0100, 32'h0);
        rd(0, 32'h0, "R3 drive flags cleared, simplex follows input");

        finished = 1'b1;
        step();
        summary();
    end

endmodule